// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns a supply-good flag from an external threshold comparator and an active-low pushbutton input into a clean processor reset. Both inputs may change at any time. Each passes through a synchroniser into the system clock domain, and the pushbutton path also has a debounce filter. Reset stays asserted for as long as any source is active. Once every source has gone quiet, a hold counter keeps reset asserted for a further fixed number of clock cycles before releasing it.

A supply dip at any moment reloads the full hold count. This covers a brownout that lands in the middle of a reset pulse already in progress: the pulse is stretched so that it ends a full hold time after the supply recovers. The reset is available in both polarities, each from its own register. The hold time, the debounce length and the synchroniser depth are parameters counted in clock cycles, so a simulation can shrink them. The default hold time is derived from the clock frequency and a duration in milliseconds.

Top module: `supv_reset_gen`

## Requirements
- R1: While `arst_n` is low, `rst_n_o` is 0 and `rst_o` is 1, whatever the other inputs are.
- R2: When `supply_ok_i` goes low, `rst_n_o` is 0 by the third rising clock edge that sees the low level. It stays 0 for as long as `supply_ok_i` stays low.
- R3: When `supply_ok_i` rises and the manual input is idle, `rst_n_o` goes to 1 on exactly the (HOLD_CYCLES+2)-th rising edge, counting the first edge that sees the high level as edge 1.
- R4: If `supply_ok_i` dips while a hold period is running, the hold count is reloaded in full. Release then happens HOLD_CYCLES+2 edges after the recovery, counted as in R3.
- R5: After a release, any dip of `supply_ok_i` that is seen by at least one rising edge starts a new reset pulse, including a one-cycle dip. That pulse releases HOLD_CYCLES+2 edges after the recovery.
- R6: When `mr_n_i` is held low (pressed), `rst_n_o` is 0 on the (DEBOUNCE_CYCLES+3)-th edge that sees the low level.
- R7: A low pulse on `mr_n_i` seen by fewer than DEBOUNCE_CYCLES edges has no effect: `rst_n_o` stays 1.
- R8: After a valid press, `rst_n_o` goes to 1 on the (HOLD_CYCLES+DEBOUNCE_CYCLES+2)-th edge after `mr_n_i` returns high.
- R9: `rst_o` is always the complement of `rst_n_o`.
- R10: Reset stays asserted while either source is active. With the button still held, a supply recovery does not release reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| supply_ok_i | input | 1 | Supply-good flag from the threshold comparator (1 = above threshold), asynchronous |
| mr_n_i | input | 1 | Manual-reset pushbutton, active low, asynchronous |
| rst_n_o | output | 1 | Processor reset, active low, registered |
| rst_o | output | 1 | Processor reset, active high, registered |

## Verification
The main function is tried with supply dips of one cycle, a few cycles and much longer than the hold time. Comparing their release timing shows that the whole hold count is reloaded, with no remainder carried over, whatever the dip length. Pushbutton pulses just below, at and well above the debounce length show where the filter threshold lies and that the hold time is added after the debounce. A dip placed halfway through a running hold checks the stretching rule. Holding the button across a supply recovery checks that the sources are combined with OR.

// File: rtl/supv_pkg.sv
`timescale 1ns/1ps
package supv_pkg;

  // Active-high view of every reset source after synchronisation and filtering.
  typedef struct packed {
    logic supply_low;
    logic manual;
  } rst_src_t;

  function automatic logic any_source(input rst_src_t s);
    return s.supply_low | s.manual;
  endfunction

endpackage

// File: rtl/supv_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for one asynchronous level.
module supv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stage_d = d_i;
    end else begin : g_chain
      always_comb stage_d = {stage_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= {STAGES{RST_VAL}};
    else         stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/supv_debounce.sv
`timescale 1ns/1ps
// Debounce filter: the output follows the input only after the input has
// differed from it for STABLE_CYCLES consecutive samples.
module supv_debounce #(
  parameter int STABLE_CYCLES = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic raw_i,
  output logic filt_o
);

  localparam int CW = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          filt_q, filt_d;

  always_comb begin
    cnt_d  = '0;
    filt_d = filt_q;
    if (raw_i != filt_q) begin
      if (cnt_q == LAST) begin
        filt_d = raw_i;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

endmodule

// File: rtl/supv_hold.sv
`timescale 1ns/1ps
// Hold counter and registered reset outputs.
module supv_hold #(
  parameter int HOLD_CYCLES = 40,
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             src_active_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rst_n_o,
  output logic             rst_o
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rst_n_q, rst_n_d;
  logic             rst_q, rst_d;

  always_comb begin
    if (src_active_i)      cnt_d = FULL;
    else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
    else                   cnt_d = cnt_q;
    rst_n_d = !src_active_i && (cnt_d == '0);
    rst_d   = src_active_i || (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q   <= FULL;
      rst_n_q <= 1'b0;
      rst_q   <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      rst_n_q <= rst_n_d;
      rst_q   <= rst_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign rst_n_o = rst_n_q;
  assign rst_o   = rst_q;

endmodule

// File: rtl/supv_reset_gen.sv
`timescale 1ns/1ps
// Supervisory reset pulse generator, top level.
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int CLK_HZ          = 50_000_000,
  parameter int HOLD_MS         = 200,
  parameter int HOLD_CYCLES     = (CLK_HZ / 1000) * HOLD_MS,
  parameter int DEBOUNCE_CYCLES = 4,
  parameter int SYNC_STAGES     = 2,
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_ok_i,
  input  logic mr_n_i,
  output logic rst_n_o,
  output logic rst_o
);

  logic             supply_ok_s;
  logic             mr_n_s;
  logic             mr_pressed;
  logic             src_active;
  logic [CNT_W-1:0] hold_cnt;
  rst_src_t         srcs;

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_supply (
    .clk(clk), .arst_n(arst_n), .d_i(supply_ok_i), .q_o(supply_ok_s)
  );

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_mr (
    .clk(clk), .arst_n(arst_n), .d_i(mr_n_i), .q_o(mr_n_s)
  );

  supv_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) u_debounce (
    .clk(clk), .arst_n(arst_n), .raw_i(!mr_n_s), .filt_o(mr_pressed)
  );

  always_comb begin
    srcs.supply_low = !supply_ok_s;
    srcs.manual     = mr_pressed;
    src_active      = any_source(srcs);
  end

  supv_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .arst_n(arst_n), .src_active_i(src_active),
    .cnt_o(hold_cnt), .rst_n_o(rst_n_o), .rst_o(rst_o)
  );

endmodule

// File: rtl/supv_reset_gen_chk.sv
`timescale 1ns/1ps
module supv_reset_gen_chk #(
  parameter int HOLD_CYCLES = 40,
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input logic             clk,
  input logic             arst_n,
  input logic             supply_ok_s,
  input logic             mr_pressed,
  input logic             src_active,
  input logic [CNT_W-1:0] hold_cnt,
  input logic             rst_n_o,
  input logic             rst_o
);

  assert_complement_R9: assert property (@(posedge clk) disable iff (!arst_n)
    rst_o == !rst_n_o);

  assert_supply_low_R2: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok_s |=> !rst_n_o);

  assert_manual_R6: assert property (@(posedge clk) disable iff (!arst_n)
    mr_pressed |=> !rst_n_o);

  assert_release_R3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n_o) |-> (hold_cnt == '0) && $past(!src_active));

  assert_reload_R4: assert property (@(posedge clk) disable iff (!arst_n)
    src_active |=> hold_cnt == CNT_W'(HOLD_CYCLES));

  assert_countdown_R3: assert property (@(posedge clk) disable iff (!arst_n)
    (!src_active && hold_cnt != '0) |=> hold_cnt == $past(hold_cnt) - CNT_W'(1));

  assert_both_sources_R10: assert property (@(posedge clk) disable iff (!arst_n)
    (mr_pressed && supply_ok_s) |=> !rst_n_o);

endmodule

bind supv_reset_gen supv_reset_gen_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk(clk), .arst_n(arst_n), .supply_ok_s(supply_ok_s), .mr_pressed(mr_pressed),
  .src_active(src_active), .hold_cnt(hold_cnt), .rst_n_o(rst_n_o), .rst_o(rst_o)
);

// File: tb/tb_supv_reset_gen.sv
`timescale 1ns/1ps
module tb_supv_reset_gen;

  localparam int HOLD = 40;
  localparam int DEB  = 4;
  localparam int LIM  = HOLD + DEB + 30;

  logic clk = 1'b0;
  logic arst_n;
  logic supply_ok_i;
  logic mr_n_i;
  logic rst_n_o;
  logic rst_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic cmp_bad = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  supv_reset_gen #(.HOLD_CYCLES(HOLD), .DEBOUNCE_CYCLES(DEB)) dut (
    .clk(clk), .arst_n(arst_n), .supply_ok_i(supply_ok_i), .mr_n_i(mr_n_i),
    .rst_n_o(rst_n_o), .rst_o(rst_o)
  );

  // kind 0 = supply dip, 1 = button press
  typedef struct packed {
    logic kind;
    int   len;
    logic exp_low;
    int   exp_rel;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1,         1'b1, HOLD + 2},        // R5 one-cycle dip
    '{1'b0, 5,         1'b1, HOLD + 2},        // R5
    '{1'b0, HOLD + 20, 1'b1, HOLD + 2},        // R5 long dip
    '{1'b1, 1,         1'b0, 0},               // R7 glitch
    '{1'b1, DEB - 1,   1'b0, 0},               // R7 just below
    '{1'b1, DEB,       1'b1, HOLD + DEB + 2},  // R8 at threshold
    '{1'b1, DEB + 10,  1'b1, HOLD + DEB + 2},  // R8
    '{1'b0, 2,         1'b1, HOLD + 2}         // R5
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (arst_n === 1'b1 && rst_o !== !rst_n_o) cmp_bad = 1'b1;

  task automatic set_src(input logic kind, input logic v);
    if (kind) mr_n_i = v; else supply_ok_i = v;
  endtask

  // Count edges, the first one that sees the new level being edge 1, until rst_n_o equals val.
  task automatic edges_until(input logic val, output int n);
    n = 0;
    for (int i = 1; i <= LIM; i++) begin
      @(posedge clk); #1;
      if (rst_n_o === val) begin n = i; break; end
    end
  endtask

  task automatic pulse(input logic kind, input int len, output logic seen, output int rel);
    seen = 1'b0;
    rel  = 0;
    @(negedge clk); set_src(kind, 1'b0);
    repeat (len) begin @(posedge clk); #1; if (!rst_n_o) seen = 1'b1; end
    @(negedge clk); set_src(kind, 1'b1);
    for (int i = 1; i <= LIM; i++) begin
      @(posedge clk); #1;
      if (!rst_n_o) seen = 1'b1;
      else if (seen && rel == 0) rel = i;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int   n;
    logic seen;
    arst_n = 1'b0; supply_ok_i = 1'b1; mr_n_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rst_n_o in reset", int'(rst_n_o), 0);
    chk("R1 rst_o in reset", int'(rst_o), 1);

    // Power-up: supply low
    @(negedge clk); supply_ok_i = 1'b0; arst_n = 1'b1;
    repeat (HOLD + 10) @(posedge clk);
    #1;
    chk("R2 held while supply low", int'(rst_n_o), 0);

    @(negedge clk); supply_ok_i = 1'b1;
    edges_until(1'b1, n);
    chk("R3 power-up release edges", n, HOLD + 2);

    // Table of stimulus vectors
    foreach (VECS[k]) begin
      repeat (5) @(posedge clk);
      pulse(VECS[k].kind, VECS[k].len, seen, n);
      chk(VECS[k].kind ? "R7/R8 button asserted" : "R5 dip asserted", int'(seen), int'(VECS[k].exp_low));
      chk(VECS[k].kind ? "R8 button release edges" : "R5 dip release edges", n, VECS[k].exp_rel);
    end

    // Assert latency on a supply drop
    @(negedge clk); supply_ok_i = 1'b0;
    edges_until(1'b0, n);
    chk("R2 assert latency", n, 3);
    // Brownout in the middle of a hold period
    @(negedge clk); supply_ok_i = 1'b1;
    repeat (HOLD / 2) @(posedge clk);
    #1;
    chk("R4 still in hold", int'(rst_n_o), 0);
    @(negedge clk); supply_ok_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); supply_ok_i = 1'b1;
    edges_until(1'b1, n);
    chk("R4 stretched release edges", n, HOLD + 2);

    // Button assert latency
    @(negedge clk); mr_n_i = 1'b0;
    edges_until(1'b0, n);
    chk("R6 button assert latency", n, DEB + 3);
    // Supply cycles while button held
    @(negedge clk); supply_ok_i = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); supply_ok_i = 1'b1;
    repeat (HOLD + 10) @(posedge clk);
    #1;
    chk("R10 button keeps reset", int'(rst_n_o), 0);
    @(negedge clk); mr_n_i = 1'b1;
    edges_until(1'b1, n);
    chk("R10 release after button", n, HOLD + DEB + 2);

    // Asynchronous reset in normal operation
    @(negedge clk); arst_n = 1'b0;
    #1;
    chk("R1 async reset rst_n_o", int'(rst_n_o), 0);
    chk("R1 async reset rst_o", int'(rst_o), 1);
    @(negedge clk); arst_n = 1'b1;
    edges_until(1'b1, n);
    chk("R3 release after async reset", n, HOLD + 2);

    chk("R9 complement throughout", int'(cmp_bad), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule